// File: doc/BRIEF.md
# FSK Tag ID Demodulator

This block recovers 44-bit identifiers from a low-frequency proximity tag that answers a reader field with frequency-shift keying. It takes a stream of 8-bit samples of the field envelope and turns each sample into one bit against a fixed threshold. It then measures how many samples lie between consecutive rising edges. Each spacing becomes a short-cycle or long-cycle symbol. Runs of equal symbols are rounded into Manchester half-bits. A start-of-frame pattern that no valid Manchester symbol can produce gives the frame alignment. The pairs of half-bits that follow are shifted into an identifier register.

An identifier is reported when the following start-of-frame pattern arrives. The report is a single-cycle pulse carrying a 12-bit high word and a 32-bit low word. The same pattern opens the next frame. In find-one mode the block halts after its first report and stays halted until reset. Otherwise it keeps decoding every frame that passes.

Top module: `fsk_id_demod`

## Requirements
- R1: Only cycles with `sample_valid_i` high are processed. A sample value of 127 or more slices to 1, and a value of 126 or less slices to 0.
- R2: A spacing between 0→1 transitions of at most 8 samples is a short cycle (symbol 1). A spacing of 9 or more is a long cycle (symbol 0). The spacing counter stops at 255 and never wraps, so a carrier gap of 264 samples still counts as a long cycle.
- R3: When the symbol changes, a run of n equal cycles becomes k = (n+1)/6 half-bits for short runs and k = (n+1)/5 for long runs, with integer division. A value of k of 0 or 1 gives one half-bit, and k of 2, 3 or 4 gives that many, all with the run's symbol.
- R4: A run whose k exceeds 4 produces no half-bits, so the pair alignment of the half-bits around it is kept.
- R5: The half-bit sequence 1,1,1,0,0,0 (oldest first) is the start-of-frame pattern. After it, the pair 1,0 shifts a 0 into the identifier and the pair 0,1 shifts a 1, MSB first. The identifier is a 64-bit left-shifting register whose bit 31 moves into bit 32.
- R6: Any other pair inside a frame (1,1 or 0,0) abandons the frame and clears the identifier. Nothing is reported until a new start-of-frame pattern has been seen and a full frame has followed it.
- R7: At the next start-of-frame pattern the identifier is reported only if it is nonzero. The report is a one-cycle `id_valid_o` pulse with bits 43..32 on `id_hi_o` and bits 31..0 on `id_lo_o`. The identifier is then cleared and the pattern opens a new frame.
- R8: With `find_one_i` high, the block stops after its first report and makes no further reports until reset. With `find_one_i` low it reports every nonzero frame. A zero frame never triggers the halt.
- R9: During and right after reset, `id_valid_o`, `id_hi_o` and `id_lo_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Envelope sample |
| sample_valid_i | input | 1 | Sample qualifier |
| find_one_i | input | 1 | Halt after the first reported identifier |
| id_valid_o | output | 1 | One-cycle pulse when a new identifier is reported |
| id_hi_o | output | 12 | Identifier bits 43..32 |
| id_lo_o | output | 32 | Identifier bits 31..0 |

## Verification
Internal errors do not show at once at the ports. A wrong slicing threshold, a misclassified spacing or a bad run rounding shows up as a missing or wrong identifier at the next start-of-frame pattern, about 88 half-bits or some 4,300 samples later. An extra or dropped half-bit shifts the pair alignment, and the frame is then either abandoned silently or reported with a corrupted value. Each scenario therefore checks how many reports arrive and the exact values reported. This covers clean frames, fuzzy and boundary periods, threshold-level samples, gapped valid, a corrupt pair, an overlong run and a long carrier gap.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_DATA = 2'd1,
    FR_HALT = 2'd2
  } fr_mode_e;

  // oldest half-bit in the MSB
  localparam logic [5:0] SOF_PATTERN = 6'b111000;
endpackage

// File: rtl/fsk_slicer_timer.sv
module fsk_slicer_timer #(
  parameter int SMP_W     = 8,
  parameter int THRESH    = 127,
  parameter int SPC_W     = 8,
  parameter int SHORT_MAX = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] sample_i,
  input  logic             sample_valid_i,
  output logic             cyc_valid_o,
  output logic             cyc_short_o
);
  localparam logic [SPC_W-1:0] SPC_MAX = '1;

  logic             lvl, rise;
  logic             prev_q, have_ref_q;
  logic [SPC_W-1:0] spc_q, spc_inc;

  assign lvl     = (sample_i >= SMP_W'(THRESH));
  assign rise    = !prev_q && lvl;
  assign spc_inc = (spc_q == SPC_MAX) ? spc_q : spc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= 1'b1;  // no false edge on a high first sample
      have_ref_q  <= 1'b0;
      spc_q       <= '0;
      cyc_valid_o <= 1'b0;
      cyc_short_o <= 1'b0;
    end else begin
      cyc_valid_o <= 1'b0;
      if (sample_valid_i) begin
        prev_q <= lvl;
        if (rise) begin
          cyc_valid_o <= have_ref_q;  // first edge only sets the reference
          cyc_short_o <= (spc_inc <= SPC_W'(SHORT_MAX));
          spc_q       <= '0;
          have_ref_q  <= 1'b1;
        end else if (have_ref_q) begin
          spc_q <= spc_inc;
        end
      end
    end
  end

  a_r2_spacing_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !rise && have_ref_q) |=> (spc_q >= $past(spc_q)));

  a_r2_spacing_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !rise && spc_q == SPC_MAX) |=> (spc_q == SPC_MAX));

  a_r1_idle_no_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !cyc_valid_o);
endmodule

// File: rtl/fsk_run_grouper.sv
module fsk_run_grouper #(
  parameter int RUN_W     = 8,
  parameter int SHORT_DIV = 6,
  parameter int LONG_DIV  = 5,
  parameter int MAX_HB    = 4,
  parameter int HB_W      = $clog2(MAX_HB + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cyc_valid_i,
  input  logic            cyc_short_i,
  output logic            grp_valid_o,
  output logic            grp_sym_o,
  output logic [HB_W-1:0] grp_cnt_o
);
  logic             have_q, run_sym_q;
  logic [RUN_W-1:0] len_q;
  logic [RUN_W:0]   len_p1, nhb;
  logic [HB_W-1:0]  emit_cnt;

  assign len_p1 = {1'b0, len_q} + 1'b1;
  assign nhb    = run_sym_q ? len_p1 / (RUN_W+1)'(SHORT_DIV)
                            : len_p1 / (RUN_W+1)'(LONG_DIV);

  always_comb begin
    if (nhb <= (RUN_W+1)'(1))           emit_cnt = HB_W'(1);
    else if (nhb <= (RUN_W+1)'(MAX_HB)) emit_cnt = HB_W'(nhb);
    else                                emit_cnt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q      <= 1'b0;
      run_sym_q   <= 1'b0;
      len_q       <= '0;
      grp_valid_o <= 1'b0;
      grp_sym_o   <= 1'b0;
      grp_cnt_o   <= '0;
    end else begin
      grp_valid_o <= 1'b0;
      if (cyc_valid_i) begin
        if (!have_q) begin
          have_q    <= 1'b1;
          run_sym_q <= cyc_short_i;
          len_q     <= RUN_W'(1);
        end else if (cyc_short_i == run_sym_q) begin
          if (len_q != '1) len_q <= len_q + 1'b1;
        end else begin
          grp_valid_o <= (emit_cnt != '0);
          grp_sym_o   <= run_sym_q;
          grp_cnt_o   <= emit_cnt;
          run_sym_q   <= cyc_short_i;
          len_q       <= RUN_W'(1);
        end
      end
    end
  end

  a_r4_group_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> (grp_cnt_o != '0 && grp_cnt_o <= HB_W'(MAX_HB)));

  a_r3_group_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> ($past(cyc_valid_i) && ($past(cyc_short_i) != grp_sym_o)));
endmodule

// File: rtl/fsk_frame_sync.sv
module fsk_frame_sync
  import fsk_pkg::*;
#(
  parameter int MAX_HB  = 4,
  parameter int HB_W    = $clog2(MAX_HB + 1),
  parameter int ID_W    = 64,
  parameter int ID_HI_W = 12,
  parameter int ID_LO_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               grp_valid_i,
  input  logic               grp_sym_i,
  input  logic [HB_W-1:0]    grp_cnt_i,
  input  logic               find_one_i,
  output logic               id_valid_o,
  output logic [ID_HI_W-1:0] id_hi_o,
  output logic [ID_LO_W-1:0] id_lo_o
);
  typedef struct packed {
    fr_mode_e        mode;
    logic [5:0]      win;
    logic [2:0]      fill;
    logic [ID_W-1:0] id;
  } fr_st_t;

  fr_st_t          st_q, st_d;
  logic            rep_d, rep_vld_q;
  logic [ID_W-1:0] rep_id_d, rep_q;

  // up to MAX_HB half-bits are consumed in one cycle
  always_comb begin
    st_d     = st_q;
    rep_d    = 1'b0;
    rep_id_d = rep_q;
    for (int k = 0; k < MAX_HB; k++) begin
      if (grp_valid_i && (HB_W'(k) < grp_cnt_i)) begin
        case (st_d.mode)
          FR_HUNT: begin
            st_d.win = {st_d.win[4:0], grp_sym_i};
            if (st_d.fill != 3'd6) st_d.fill = st_d.fill + 3'd1;
            if (st_d.fill == 3'd6 && st_d.win == SOF_PATTERN) begin
              st_d.mode = FR_DATA;
              st_d.fill = 3'd0;
              st_d.id   = '0;
            end
          end
          FR_DATA: begin
            st_d.win  = {st_d.win[4:0], grp_sym_i};
            st_d.fill = st_d.fill + 3'd1;
            // decode the oldest pair only once a marker is ruled out
            if (st_d.fill == 3'd6) begin
              if (st_d.win == SOF_PATTERN) begin
                if (st_d.id != '0) begin
                  rep_d    = 1'b1;
                  rep_id_d = st_d.id;
                  if (find_one_i) st_d.mode = FR_HALT;
                end
                st_d.id   = '0;
                st_d.fill = 3'd0;
              end else begin
                case (st_d.win[5:4])
                  2'b10:   st_d.id = {st_d.id[ID_W-2:0], 1'b0};
                  2'b01:   st_d.id = {st_d.id[ID_W-2:0], 1'b1};
                  default: begin
                    st_d.mode = FR_HUNT;
                    st_d.id   = '0;
                  end
                endcase
                st_d.fill = 3'd4;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= '{mode: FR_HUNT, win: '0, fill: '0, id: '0};
      rep_vld_q <= 1'b0;
      rep_q     <= '0;
    end else begin
      st_q      <= st_d;
      rep_vld_q <= rep_d;
      if (rep_d) rep_q <= rep_id_d;
    end
  end

  assign id_valid_o = rep_vld_q;
  assign id_hi_o    = rep_q[ID_LO_W +: ID_HI_W];
  assign id_lo_o    = rep_q[ID_LO_W-1:0];

  a_r7_report_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_vld_q |-> (rep_q != '0));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |=> !id_valid_o);

  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q.mode == FR_HALT) |=> (st_q.mode == FR_HALT && !id_valid_o));

  a_r8_find_one_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_o && $past(find_one_i)) |-> (st_q.mode == FR_HALT));

  a_r6_hunt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q.mode == FR_HUNT) |-> (st_q.id == '0));
endmodule

// File: rtl/fsk_id_demod.sv
module fsk_id_demod #(
  parameter int SMP_W     = 8,
  parameter int THRESH    = 127,
  parameter int SPC_W     = 8,
  parameter int SHORT_MAX = 8,
  parameter int RUN_W     = 8,
  parameter int SHORT_DIV = 6,
  parameter int LONG_DIV  = 5,
  parameter int MAX_HB    = 4,
  parameter int ID_W      = 64,
  parameter int ID_HI_W   = 12,
  parameter int ID_LO_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SMP_W-1:0]   sample_i,
  input  logic               sample_valid_i,
  input  logic               find_one_i,
  output logic               id_valid_o,
  output logic [ID_HI_W-1:0] id_hi_o,
  output logic [ID_LO_W-1:0] id_lo_o
);
  localparam int HB_W = $clog2(MAX_HB + 1);

  logic            cyc_valid, cyc_short;
  logic            grp_valid, grp_sym;
  logic [HB_W-1:0] grp_cnt;

  fsk_slicer_timer #(
    .SMP_W(SMP_W), .THRESH(THRESH), .SPC_W(SPC_W), .SHORT_MAX(SHORT_MAX)
  ) u_timer (
    .clk_i, .rst_ni,
    .sample_i, .sample_valid_i,
    .cyc_valid_o (cyc_valid),
    .cyc_short_o (cyc_short)
  );

  fsk_run_grouper #(
    .RUN_W(RUN_W), .SHORT_DIV(SHORT_DIV), .LONG_DIV(LONG_DIV),
    .MAX_HB(MAX_HB), .HB_W(HB_W)
  ) u_group (
    .clk_i, .rst_ni,
    .cyc_valid_i (cyc_valid),
    .cyc_short_i (cyc_short),
    .grp_valid_o (grp_valid),
    .grp_sym_o   (grp_sym),
    .grp_cnt_o   (grp_cnt)
  );

  fsk_frame_sync #(
    .MAX_HB(MAX_HB), .HB_W(HB_W), .ID_W(ID_W),
    .ID_HI_W(ID_HI_W), .ID_LO_W(ID_LO_W)
  ) u_frame (
    .clk_i, .rst_ni,
    .grp_valid_i (grp_valid),
    .grp_sym_i   (grp_sym),
    .grp_cnt_i   (grp_cnt),
    .find_one_i,
    .id_valid_o,
    .id_hi_o,
    .id_lo_o
  );
endmodule

// File: tb/sim_fsk_id_demod.sv
`timescale 1ns/1ps
module sim_fsk_id_demod;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  smp = 8'd0;
  logic        vld = 1'b0;
  logic        find_one = 1'b0;
  logic        id_valid;
  logic [11:0] id_hi;
  logic [31:0] id_lo;

  always #4 clk = ~clk;  // 125 MHz

  fsk_id_demod u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .sample_valid_i(vld),
    .find_one_i(find_one), .id_valid_o(id_valid), .id_hi_o(id_hi), .id_lo_o(id_lo)
  );

  int n_chk = 0;
  int n_fail = 0;
  int rep_n = 0;
  logic [43:0] seen [16];

  always @(negedge clk) begin
    if (id_valid) begin
      seen[rep_n % 16] <= {id_hi, id_lo};
      rep_n <= rep_n + 1;
    end
  end

  logic [7:0] hi_lvl = 8'd200, lo_lvl = 8'd20;
  int s_per = 8, l_per = 10;
  bit gap_en = 1'b0;

  typedef struct packed {
    logic [43:0] id1;
    logic [43:0] id2;
    logic        fo;
    logic [7:0]  hl;
    logic [7:0]  ll;
    logic [3:0]  sp;
    logic [3:0]  lp;
    logic        gap;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{44'h2AB12345678, 44'h0F189ABCDEF, 1'b0, 8'd200, 8'd20,  4'd8, 4'd10, 1'b0},
    '{44'h2AB12345678, 44'h0F189ABCDEF, 1'b1, 8'd200, 8'd20,  4'd8, 4'd10, 1'b0},
    '{44'h2AB12345678, 44'h0F189ABCDEF, 1'b0, 8'd127, 8'd126, 4'd8, 4'd10, 1'b0},
    '{44'h5A5C3C3C3C3, 44'h123DEADBEEF, 1'b0, 8'd255, 8'd0,   4'd7, 4'd11, 1'b0},
    '{44'h2AB12345678, 44'h0F189ABCDEF, 1'b0, 8'd200, 8'd20,  4'd8, 4'd9,  1'b0},
    '{44'h00000000000, 44'h0F189ABCDEF, 1'b1, 8'd200, 8'd20,  4'd8, 4'd10, 1'b0},
    '{44'h2AB12345678, 44'h0F189ABCDEF, 1'b0, 8'd180, 8'd40,  4'd8, 4'd10, 1'b1},
    '{44'h00000000001, 44'hFFFFFFFFFFF, 1'b0, 8'd200, 8'd20,  4'd8, 4'd10, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put_smp(input logic [7:0] v);
    @(negedge clk);
    smp = v;
    vld = 1'b1;
    if (gap_en) begin
      @(negedge clk);
      vld = 1'b0;
    end
  endtask

  task automatic cyc(input int per);
    for (int i = 0; i < per; i++) put_smp(i < 3 ? hi_lvl : lo_lvl);
  endtask

  task automatic half(input bit h);
    repeat (h ? 6 : 5) cyc(h ? s_per : l_per);
  endtask

  task automatic marker();
    half(1); half(1); half(1); half(0); half(0); half(0);
  endtask

  // bad_at: bit index before which an invalid pair 1,1 is sent
  task automatic frame(input logic [43:0] id, input int bad_at, input bit junk_en);
    bit junk_done = 1'b0;
    for (int b = 43; b >= 0; b--) begin
      if (b == bad_at) begin half(1); half(1); end
      if (junk_en && !junk_done && b < 43 && !id[b+1] && id[b]) begin
        repeat (30) cyc(s_per);  // 31/6 = 5 half-bits: dropped
        junk_done = 1'b1;
      end
      if (id[b]) begin half(0); half(1); end
      else       begin half(1); half(0); end
    end
  endtask

  task automatic lead();
    cyc(s_per); cyc(s_per);
  endtask

  task automatic tail();
    half(1);
    @(negedge clk);
    vld = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    vld = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base, got, exp_n;
    logic [43:0] exp_first, exp_last;

    // R9: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(id_valid == 1'b0, "R9", "id_valid in reset", 64'(id_valid), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(id_hi == 12'd0, "R9", "id_hi after reset", 64'(id_hi), 64'd0);
    chk(id_lo == 32'd0, "R9", "id_lo after reset", 64'(id_lo), 64'd0);

    // vector table: R1 R2 R3 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      hi_lvl = VEC[v].hl;  lo_lvl = VEC[v].ll;
      s_per  = int'(VEC[v].sp);  l_per = int'(VEC[v].lp);
      gap_en = VEC[v].gap;
      find_one = VEC[v].fo;
      do_reset();
      base = rep_n;
      lead(); marker();
      frame(VEC[v].id1, -1, 1'b0); marker();
      frame(VEC[v].id2, -1, 1'b0); marker();
      tail();
      got = rep_n - base;
      if (VEC[v].fo) exp_n = (VEC[v].id1 != 0 || VEC[v].id2 != 0) ? 1 : 0;
      else           exp_n = int'(VEC[v].id1 != 0) + int'(VEC[v].id2 != 0);
      exp_first = (VEC[v].id1 != 0) ? VEC[v].id1 : VEC[v].id2;
      exp_last  = (VEC[v].id2 != 0) ? VEC[v].id2 : VEC[v].id1;
      chk(got == exp_n, "R7/R8", $sformatf("report count vector %0d", v),
          64'(got), 64'(exp_n));
      if (exp_n >= 1 && got >= 1)
        chk(seen[base % 16] == exp_first, "R1/R2/R3/R5",
            $sformatf("first id vector %0d", v), 64'(seen[base % 16]), 64'(exp_first));
      if (exp_n == 2 && got == 2)
        chk(seen[(base + 1) % 16] == exp_last, "R5/R8",
            $sformatf("second id vector %0d", v), 64'(seen[(base + 1) % 16]), 64'(exp_last));
    end

    hi_lvl = 8'd200; lo_lvl = 8'd20; s_per = 8; l_per = 10; gap_en = 1'b0;
    find_one = 1'b0;

    // R6: invalid pair abandons frame, next frame after a fresh marker decodes
    do_reset();
    base = rep_n;
    lead(); marker();
    frame(44'h2AB12345678, 20, 1'b0); marker();
    frame(44'h0F189ABCDEF, -1, 1'b0); marker();
    tail();
    got = rep_n - base;
    chk(got == 1, "R6", "reports after abort", 64'(got), 64'd1);
    if (got >= 1)
      chk(seen[base % 16] == 44'h0F189ABCDEF, "R6", "id after abort",
          64'(seen[base % 16]), 64'h0F189ABCDEF);

    // R4: overlong run inside a frame produces nothing
    do_reset();
    base = rep_n;
    lead(); marker();
    frame(44'h2AB12345678, -1, 1'b1); marker();
    tail();
    got = rep_n - base;
    chk(got == 1, "R4", "reports with overlong run", 64'(got), 64'd1);
    if (got >= 1)
      chk(seen[base % 16] == 44'h2AB12345678, "R4", "id with overlong run",
          64'(seen[base % 16]), 64'h2AB12345678);

    // R2: 264-sample carrier gap must stay a long cycle (no wrap)
    do_reset();
    base = rep_n;
    lead();
    half(1); half(1); half(1);
    repeat (14) cyc(l_per);
    cyc(264);
    frame(44'h2AB12345678, -1, 1'b0); marker();
    tail();
    got = rep_n - base;
    chk(got == 1, "R2", "reports after carrier gap", 64'(got), 64'd1);
    if (got >= 1)
      chk(seen[base % 16] == 44'h2AB12345678, "R2", "id after carrier gap",
          64'(seen[base % 16]), 64'h2AB12345678);

    // R9: reset clears a reported value
    do_reset();
    chk(id_hi == 12'd0 && id_lo == 32'd0 && !id_valid, "R9", "outputs after re-reset",
        64'({id_hi, id_lo}), 64'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule